// File: doc/BRIEF.md
# ATM Transmit GFC Flow-Control Scheduler

This block picks, once per transmit cell slot, which cell goes onto the line: a cell taken from the transmit FIFO, an inserted unassigned cell, or an idle cell. It also produces the 4-bit Generic Flow Control (GFC) nibble for that cell's header. Payload transfer and header checksum generation are handled elsewhere. The block only issues a FIFO read strobe, a cell-type select and the GFC value.

Two flow-control roles are available, and at most one may be on at a time. In the controlling role, the halt bit (GFC bit 3) follows a programmable pattern: N halted cells, then one cell without the halt bit, repeated. In the controlled role, every outgoing cell carries the controlled flag (GFC bit 0). Each halt reported by the receive side also queues one unassigned cell, which is sent ahead of FIFO traffic. A read-enable input stops all FIFO reads, and the slot then goes out idle.

The slot request is a plain one-cycle strobe and the decision is a one-cycle pulse. The line side takes one cell per slot and never stalls, so neither side has back-pressure. The FIFO read strobe has no handshake: the FIFO must present its next cell header by the following slot.

Top module: `atm_gfc_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, `dec_valid_o` and `fifo_rd_o` are 0. Reset clears the pending-unassigned count and the halt-pattern phase.
- R2: A decision comes one cycle after each slot strobe: `dec_valid_o` pulses for one cycle. A FIFO cell (`cell_sel_o` = 01) is chosen when `read_en_i` = 1, `cell_avail_i` = 1 and no unassigned cell is pending. In that case `fifo_rd_o` pulses in the same cycle, and `gfc_o` equals `fifo_gfc_i` except for the bits that a mode overrides.
- R3: With no cell available and nothing pending, an idle cell is sent: `cell_sel_o` = 00, `gfc_o` = 0000, and there is no FIFO read.
- R4: With `read_en_i` = 0, no FIFO read happens even when a cell is available. The slot carries an idle cell unless an unassigned cell is pending.
- R5: In the controlling role, GFC bit 3 of every FIFO cell is replaced by the halt pattern. When `halt_cnt_i` = 0, bit 3 is always 0.
- R6: In the controlled role, GFC bit 0 is 1 in every FIFO and unassigned cell.
- R7: In the controlled role, each `rx_halt_i` pulse queues one unassigned cell (`cell_sel_o` = 10, `gfc_o` = 0001, no FIFO read). A queued unassigned cell takes the next slot ahead of any FIFO cell, whatever the value of `read_en_i`.
- R8: When both roles are requested, `cfg_err_o` = 1 and neither role acts: the GFC passes through unchanged and halts are not queued.
- R9: For a count N, the halt bit is 1 in N consecutive sent cells and 0 in the next, repeating. Idle slots do not advance the pattern.
- R10: The pending-unassigned count saturates at 15. Further halts are dropped until the count falls.
- R11: `rx_halt_i` pulses outside the controlled role have no effect on later slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_i | input | 1 | One-cycle request for the next cell slot decision |
| cell_avail_i | input | 1 | The transmit FIFO holds at least one complete cell |
| fifo_gfc_i | input | 4 | GFC nibble of the cell at the FIFO head |
| read_en_i | input | 1 | 1 allows FIFO reads, 0 forces idle cells |
| ctrlr_en_i | input | 1 | Enables the controlling role |
| ctrld_en_i | input | 1 | Enables the controlled role |
| halt_cnt_i | input | 3 | Halted cells per non-halted cell (N) |
| rx_halt_i | input | 1 | A received cell carried the halt bit |
| dec_valid_o | output | 1 | Decision pulse |
| fifo_rd_o | output | 1 | FIFO read strobe, valid with the decision |
| cell_sel_o | output | 2 | Cell type: 00 idle, 01 FIFO, 10 unassigned |
| gfc_o | output | 4 | GFC nibble for the chosen cell |
| cfg_err_o | output | 1 | Both roles requested at once |

## Verification
Every slot decision (`dec_valid_o`, `fifo_rd_o`, `cell_sel_o`, `gfc_o`) appears in the cycle after the edge that samples `slot_i`. The bench therefore raises the strobe at a falling edge, drops it at the next falling edge and reads the outputs there. `cfg_err_o` follows the role inputs in the same cycle. A halt pulse is counted at the edge that samples it and affects only later slots, so the bench finishes each halt pulse before it requests a slot. The checker properties look one cycle ahead of the slot strobe, which matches this latency.

// File: rtl/atm_gfc_pkg.sv
package atm_gfc_pkg;
  localparam int GFC_W  = 4;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_IDLE  = 2'b00,
    SEL_FIFO  = 2'b01,
    SEL_UNASG = 2'b10
  } cell_sel_e;

  localparam int HALT_BIT = GFC_W - 1;
  localparam int CTLD_BIT = 0;
endpackage

// File: rtl/gfc_ratio_gen.sv
module gfc_ratio_gen #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] n_i,
  input  logic             adv_i,
  output logic             halt_o
);
  logic [CNT_W-1:0] phase_q;

  // halted while phase is below N; the final phase of a period is non-halted
  assign halt_o = en_i && (phase_q < n_i);

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      phase_q <= '0;
    end else if (adv_i) begin
      if (phase_q >= n_i) phase_q <= '0;
      else                phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/halt_pend_ctr.sv
module halt_pend_ctr #(
  parameter int PEND_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic inc_i,
  input  logic dec_i,
  output logic nz_o
);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic [PEND_W-1:0] cnt_q;

  assign nz_o = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      cnt_q <= '0;
    end else begin
      unique case ({inc_i, dec_i && nz_o})
        2'b10:   if (cnt_q != PEND_MAX) cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/atm_gfc_sched.sv
module atm_gfc_sched
  import atm_gfc_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int PEND_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_i,
  input  logic             cell_avail_i,
  input  logic [GFC_W-1:0] fifo_gfc_i,
  input  logic             read_en_i,
  input  logic             ctrlr_en_i,
  input  logic             ctrld_en_i,
  input  logic [CNT_W-1:0] halt_cnt_i,
  input  logic             rx_halt_i,
  output logic             dec_valid_o,
  output logic             fifo_rd_o,
  output logic [SEL_W-1:0] cell_sel_o,
  output logic [GFC_W-1:0] gfc_o,
  output logic             cfg_err_o
);
  logic ctrlr_act, ctrld_act;
  logic halt_bit, pend_nz;
  logic use_unasg, use_fifo, sent;
  cell_sel_e sel_d;
  logic [GFC_W-1:0] gfc_d;

  assign cfg_err_o = ctrlr_en_i && ctrld_en_i;
  assign ctrlr_act = ctrlr_en_i && !ctrld_en_i;
  assign ctrld_act = ctrld_en_i && !ctrlr_en_i;

  assign use_unasg = pend_nz;
  assign use_fifo  = !pend_nz && read_en_i && cell_avail_i;
  assign sent      = slot_i && (use_unasg || use_fifo);

  gfc_ratio_gen #(.CNT_W(CNT_W)) u_ratio (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (ctrlr_act),
    .n_i    (halt_cnt_i),
    .adv_i  (sent),
    .halt_o (halt_bit)
  );

  halt_pend_ctr #(.PEND_W(PEND_W)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (ctrld_act),
    .inc_i (rx_halt_i),
    .dec_i (slot_i),
    .nz_o  (pend_nz)
  );

  always_comb begin
    sel_d = SEL_IDLE;
    gfc_d = '0;
    if (use_unasg) begin
      sel_d = SEL_UNASG;
    end else if (use_fifo) begin
      sel_d = SEL_FIFO;
      gfc_d = fifo_gfc_i;
    end
    if (sel_d != SEL_IDLE) begin
      if (ctrlr_act) gfc_d[HALT_BIT] = halt_bit;
      if (ctrld_act) gfc_d[CTLD_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid_o <= 1'b0;
      fifo_rd_o   <= 1'b0;
      cell_sel_o  <= SEL_IDLE;
      gfc_o       <= '0;
    end else begin
      dec_valid_o <= slot_i;
      fifo_rd_o   <= slot_i && use_fifo;
      if (slot_i) begin
        cell_sel_o <= sel_d;
        gfc_o      <= gfc_d;
      end
    end
  end
endmodule

// File: rtl/atm_gfc_sched_chk.sv
module atm_gfc_sched_chk
  import atm_gfc_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slot_i,
  input logic             cell_avail_i,
  input logic [GFC_W-1:0] fifo_gfc_i,
  input logic             read_en_i,
  input logic             ctrlr_en_i,
  input logic             ctrld_en_i,
  input logic [CNT_W-1:0] halt_cnt_i,
  input logic             dec_valid_o,
  input logic             fifo_rd_o,
  input logic [SEL_W-1:0] cell_sel_o,
  input logic [GFC_W-1:0] gfc_o,
  input logic             cfg_err_o
);
  // R1
  rd_needs_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_o |-> dec_valid_o && cell_sel_o == SEL_FIFO);

  // R2
  dec_follows_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_i |=> dec_valid_o);

  // R3
  no_rd_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i && !cell_avail_i) |=> !fifo_rd_o);

  // R4
  no_rd_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i && !read_en_i) |=> !fifo_rd_o && cell_sel_o != SEL_FIFO);

  // R5
  halt_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i && ctrlr_en_i && !ctrld_en_i && halt_cnt_i == '0) |=> !gfc_o[HALT_BIT]);

  // R6
  ctld_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i && ctrld_en_i && !ctrlr_en_i) |=> cell_sel_o == SEL_IDLE || gfc_o[CTLD_BIT]);

  // R8
  cfg_err_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i && cfg_err_o) |=> cell_sel_o != SEL_FIFO || gfc_o == $past(fifo_gfc_i));
endmodule

bind atm_gfc_sched atm_gfc_sched_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .slot_i       (slot_i),
  .cell_avail_i (cell_avail_i),
  .fifo_gfc_i   (fifo_gfc_i),
  .read_en_i    (read_en_i),
  .ctrlr_en_i   (ctrlr_en_i),
  .ctrld_en_i   (ctrld_en_i),
  .halt_cnt_i   (halt_cnt_i),
  .dec_valid_o  (dec_valid_o),
  .fifo_rd_o    (fifo_rd_o),
  .cell_sel_o   (cell_sel_o),
  .gfc_o        (gfc_o),
  .cfg_err_o    (cfg_err_o)
);

// File: tb/tb_atm_gfc_sched.sv
module tb_atm_gfc_sched;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slot_i = 1'b0, cell_avail_i = 1'b0, read_en_i = 1'b1;
  logic       ctrlr_en_i = 1'b0, ctrld_en_i = 1'b0, rx_halt_i = 1'b0;
  logic [3:0] fifo_gfc_i = 4'b0;
  logic [2:0] halt_cnt_i = 3'b0;
  logic       dec_valid_o, fifo_rd_o, cfg_err_o;
  logic [1:0] cell_sel_o;
  logic [3:0] gfc_o;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;  // 50 MHz

  atm_gfc_sched dut (
    .clk(clk), .rst_n(rst_n), .slot_i(slot_i), .cell_avail_i(cell_avail_i),
    .fifo_gfc_i(fifo_gfc_i), .read_en_i(read_en_i), .ctrlr_en_i(ctrlr_en_i),
    .ctrld_en_i(ctrld_en_i), .halt_cnt_i(halt_cnt_i), .rx_halt_i(rx_halt_i),
    .dec_valid_o(dec_valid_o), .fifo_rd_o(fifo_rd_o), .cell_sel_o(cell_sel_o),
    .gfc_o(gfc_o), .cfg_err_o(cfg_err_o)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       ctrlr, ctrld;
    logic [2:0] n;
    logic       ren, avail;
    logic [3:0] gfc;
    logic [1:0] halts;
    logic [1:0] esel;
    logic       erd;
    logic [3:0] egfc;
    logic       eerr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{4'd2,  1'b0,1'b0,3'd0,1'b1,1'b1,4'b0101,2'd0, 2'b01,1'b1,4'b0101,1'b0}, // R2 plain FIFO
    '{4'd3,  1'b0,1'b0,3'd0,1'b1,1'b0,4'b0101,2'd0, 2'b00,1'b0,4'b0000,1'b0}, // R3 empty
    '{4'd4,  1'b0,1'b0,3'd0,1'b0,1'b1,4'b0101,2'd0, 2'b00,1'b0,4'b0000,1'b0}, // R4 read off
    '{4'd6,  1'b0,1'b1,3'd0,1'b1,1'b1,4'b0100,2'd0, 2'b01,1'b1,4'b0101,1'b0}, // R6 controlled flag
    '{4'd7,  1'b0,1'b1,3'd0,1'b1,1'b1,4'b0100,2'd1, 2'b10,1'b0,4'b0001,1'b0}, // R7 unassigned first
    '{4'd7,  1'b0,1'b1,3'd0,1'b0,1'b1,4'b0100,2'd1, 2'b10,1'b0,4'b0001,1'b0}, // R7 ignores read off
    '{4'd5,  1'b1,1'b0,3'd3,1'b1,1'b1,4'b0000,2'd0, 2'b01,1'b1,4'b1000,1'b0}, // R5 first halted
    '{4'd5,  1'b1,1'b0,3'd0,1'b1,1'b1,4'b1010,2'd0, 2'b01,1'b1,4'b0010,1'b0}, // R5 N=0
    '{4'd8,  1'b1,1'b1,3'd3,1'b1,1'b1,4'b0110,2'd0, 2'b01,1'b1,4'b0110,1'b1}, // R8 passthrough
    '{4'd11, 1'b0,1'b0,3'd0,1'b1,1'b1,4'b0011,2'd2, 2'b01,1'b1,4'b0011,1'b0}  // R11 halts ignored
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse_halt();
    rx_halt_i = 1'b1;
    @(negedge clk);
    rx_halt_i = 1'b0;
  endtask

  // raise slot at a falling edge; decision is readable at the next falling edge
  task automatic do_slot(input logic avail, input logic [3:0] g);
    cell_avail_i = avail;
    fifo_gfc_i   = g;
    slot_i       = 1'b1;
    @(negedge clk);
    slot_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] pat2;
    // R1: held in reset, and right after release
    repeat (2) @(negedge clk);
    chk("R1 dec_valid in reset", {7'd0, dec_valid_o}, 8'd0);
    chk("R1 fifo_rd in reset", {7'd0, fifo_rd_o}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 quiet after reset", {6'd0, dec_valid_o, fifo_rd_o}, 8'd0);

    for (int i = 0; i < NV; i++) begin
      ctrlr_en_i = VEC[i].ctrlr;
      ctrld_en_i = VEC[i].ctrld;
      halt_cnt_i = VEC[i].n;
      read_en_i  = VEC[i].ren;
      do_reset();
      for (int h = 0; h < int'(VEC[i].halts); h++) pulse_halt();
      do_slot(VEC[i].avail, VEC[i].gfc);
      chk($sformatf("R%0d vec%0d sel", VEC[i].req, i), {6'd0, cell_sel_o}, {6'd0, VEC[i].esel});
      chk($sformatf("R%0d vec%0d rd", VEC[i].req, i), {6'd0, dec_valid_o, fifo_rd_o}, {6'd0, 1'b1, VEC[i].erd});
      chk($sformatf("R%0d vec%0d gfc", VEC[i].req, i), {4'd0, gfc_o}, {4'd0, VEC[i].egfc});
      chk($sformatf("R%0d vec%0d err", VEC[i].req, i), {7'd0, cfg_err_o}, {7'd0, VEC[i].eerr});
    end

    // R9: N=2, halt pattern 1,1,0 repeating; an idle slot does not advance it
    ctrlr_en_i = 1'b1; ctrld_en_i = 1'b0; halt_cnt_i = 3'd2; read_en_i = 1'b1;
    do_reset();
    pat2 = '0;
    for (int k = 0; k < 7; k++) begin
      if (k == 2) begin
        do_slot(1'b0, 4'b0000);
        chk("R9 idle slot gfc", {4'd0, gfc_o}, 8'd0);
      end else begin
        do_slot(1'b1, 4'b0000);
        pat2 = {pat2[6:0], gfc_o[3]};
      end
    end
    // six sent cells -> 1 1 0 1 1 0
    chk("R9 N=2 pattern", pat2, 8'b0011_0110);

    // R9: N=7 gives seven halted cells then one clear
    halt_cnt_i = 3'd7;
    do_reset();
    pat2 = '0;
    for (int k = 0; k < 8; k++) begin
      do_slot(1'b1, 4'b0000);
      pat2 = {pat2[6:0], gfc_o[3]};
    end
    chk("R9 N=7 pattern", pat2, 8'b1111_1110);

    // R7 + R10: 20 halts saturate at 15 queued unassigned cells
    ctrlr_en_i = 1'b0; ctrld_en_i = 1'b1;
    do_reset();
    for (int h = 0; h < 20; h++) pulse_halt();
    for (int k = 0; k < 15; k++) begin
      do_slot(1'b1, 4'b0000);
      chk($sformatf("R10 queued slot %0d", k), {6'd0, cell_sel_o}, 8'd2);
    end
    do_slot(1'b1, 4'b1000);
    chk("R10 FIFO after 15 unassigned", {6'd0, cell_sel_o}, 8'd1);
    chk("R6 FIFO gfc in controlled role", {4'd0, gfc_o}, 8'h09);

    // R7: three halts give exactly three unassigned cells
    do_reset();
    for (int h = 0; h < 3; h++) pulse_halt();
    for (int k = 0; k < 4; k++) begin
      do_slot(1'b1, 4'b0000);
      chk($sformatf("R7 slot %0d", k), {6'd0, cell_sel_o}, (k < 3) ? 8'd2 : 8'd1);
    end

    // R8: with both roles requested, halts are not queued
    ctrlr_en_i = 1'b1;
    do_reset();
    pulse_halt();
    do_slot(1'b1, 4'b0100);
    chk("R8 halt not queued", {6'd0, cell_sel_o}, 8'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule